// File: doc/BRIEF.md
# Half-Duplex Carrier-Sense and Collision Qualifier

This block produces the carrier-sense (`crs`) and collision (`col`) outputs of a dual-speed Ethernet media interface. It runs on one system clock. A one-cycle strobe `bit_stb` marks each line bit time. Around it are the transmit, receive and link indications from the rest of the physical layer. Three small state machines do the work: a collision qualifier, a post-transmit heartbeat generator and a start-of-stream detector for 100 Mb/s operation. The top combines their results into the two outputs.

The collision qualifier has three states. `CQ_IDLE` is entered on reset or link loss. `CQ_WAIT` is the 10 Mb/s transmit-first noise filter, which counts strobes. `CQ_HIT` means a collision is being reported. The transitions are: onset to WAIT or HIT, qualify (WAIT to HIT after the seventh strobe), abandon (WAIT to IDLE) and release (HIT to IDLE).

The heartbeat generator also has three states. `HB_IDLE` goes to `HB_DELAY` when a transmission ends at 10 Mb/s with heartbeat enabled. `HB_DELAY` goes to `HB_PULSE` after ten strobes, or back to IDLE if a new transmission starts first (cancel). `HB_PULSE` returns to IDLE after ten strobes.

The start-of-stream detector has three states. `SD_HUNT` goes to `SD_ARMED` on a zero bit. `SD_ARMED` goes to `SD_LOCK` on a second zero that is not adjacent to the first, restarts on an adjacent zero (re-arm), and returns to HUNT when its window expires. `SD_LOCK` is left only on end of packet, link loss or a speed change.

Top module: `mii_sense_ctrl`

## Requirements
- R1: A collision is recognised only when `full_dup` is 0 and both `tx_act` and `rx_vld` are 1; in full duplex, or with only one channel active, `col` stays 0.
- R2: At 10 Mb/s (`spd_100`=0), when a collision starts without receive having been active in the previous cycle, `col` stays 0 until the seventh `bit_stb` pulse seen in the collision condition, and rises in the cycle after that pulse.
- R3: When a collision starts with receive already active in the previous cycle, or at 100 Mb/s, `col` rises in the cycle after the condition first holds.
- R4: `col` stays 1 while the collision condition lasts and falls in the cycle after the condition ends.
- R5: With `hb_en`=1 and `spd_100`=0, the first cycle with `tx_act` low after a high starts a delay. After 10 strobes `col` rises in the next cycle. It falls in the cycle after 10 further strobes. No pulse is produced with `hb_en`=0 or at 100 Mb/s.
- R6: If `tx_act` rises during the heartbeat delay, the pending pulse is cancelled. A full new delay starts when that transmission ends.
- R7: In half duplex `crs` is 1 whenever `tx_act` or receive carrier is present. In full duplex only receive carrier drives it. At 10 Mb/s receive carrier is `rx_vld`.
- R8: At 100 Mb/s receive carrier is present only while `link_ok` is 1 and the detector is locked. Lock needs a zero on `rx_bit` at a strobe, then a second zero at a strobe that is 2 to 10 strobes after the first.
- R9: A zero at the strobe right after the first zero does not lock. It becomes the new first zero.
- R10: If ten strobes of ones follow the first zero, the search restarts and waits for a new first zero.
- R11: `crs` from receive falls in the cycle after a one-cycle `eop` pulse at 100 Mb/s, and in the cycle `rx_vld` falls at 10 Mb/s.
- R12: Reset or `link_ok`=0 forces `crs` and `col` to 0 and returns every state machine and counter to idle, so that an activity still present when the link returns is qualified afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | One-cycle pulse per line bit time |
| spd_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_dup | input | 1 | 1 = full duplex, 0 = half duplex |
| hb_en | input | 1 | Heartbeat (SQE) enable |
| tx_act | input | 1 | Transmit channel active |
| rx_vld | input | 1 | Receive channel active |
| eop | input | 1 | One-cycle end-of-packet pulse |
| link_ok | input | 1 | Link / signal detect valid |
| rx_bit | input | 1 | Serial receive bit, sampled on `bit_stb` |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision / heartbeat indication |

## Verification
The assertions rely on four assumptions about the inputs. Reset is held from time zero. `rx_bit` matters only in cycles where `bit_stb` is high. `eop` and `bit_stb` are single-cycle pulses. Speed and duplex change only while the line is quiet. The stimulus follows these rules. Every strobe is one isolated high cycle followed by a low cycle. `spd_100`, `full_dup` and `hb_en` are changed only while `tx_act` and `rx_vld` are both low. `link_ok` is dropped only in the scenario that tests it.

// File: rtl/sense_pkg.sv
package sense_pkg;
    typedef enum logic [1:0] {CQ_IDLE, CQ_WAIT, CQ_HIT}    cq_state_t;
    typedef enum logic [1:0] {HB_IDLE, HB_DELAY, HB_PULSE} hb_state_t;
    typedef enum logic [1:0] {SD_HUNT, SD_ARMED, SD_LOCK}  sd_state_t;
endpackage

// File: rtl/col_qual.sv
module col_qual
    import sense_pkg::*;
#(
    parameter int QUAL_BITS = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic link_ok,
    input  logic bit_stb,
    input  logic spd_100,
    input  logic full_dup,
    input  logic tx_act,
    input  logic rx_vld,
    output logic col_hit
);
    localparam int CW = $clog2(QUAL_BITS + 1);

    cq_state_t state, nxt;
    logic [CW-1:0] cnt, cnt_n;
    logic rx_prev;
    logic coll_cond;

    assign coll_cond = !full_dup && tx_act && rx_vld;

    always_ff @(posedge clk) begin
        if (rst || !link_ok) begin
            state   <= CQ_IDLE;
            cnt     <= '0;
            rx_prev <= 1'b0;
        end else begin
            state   <= nxt;
            cnt     <= cnt_n;
            rx_prev <= rx_vld;
        end
    end

    always_comb begin
        nxt   = state;
        cnt_n = cnt;
        unique case (state)
            CQ_IDLE: begin
                if (coll_cond) begin
                    cnt_n = '0;
                    // transmit-first at 10 Mb/s is filtered; otherwise report at once
                    nxt   = (!spd_100 && !rx_prev) ? CQ_WAIT : CQ_HIT;
                end
            end
            CQ_WAIT: begin
                if (!coll_cond) begin
                    nxt   = CQ_IDLE;
                    cnt_n = '0;
                end else if (bit_stb) begin
                    if (cnt == CW'(QUAL_BITS - 1)) begin
                        nxt   = CQ_HIT;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
            end
            CQ_HIT: begin
                if (!coll_cond) nxt = CQ_IDLE;
            end
            default: nxt = CQ_IDLE;
        endcase
    end

    always_comb begin
        col_hit = (state == CQ_HIT);
    end

    p_fdx_no_hit_r1: assert property (@(posedge clk) disable iff (rst)
        full_dup |=> state != CQ_HIT);
    p_wait_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (state == CQ_WAIT) |-> (cnt < CW'(QUAL_BITS)));
    p_rx_first_r3: assert property (@(posedge clk) disable iff (rst)
        (state == CQ_IDLE && coll_cond && rx_prev && link_ok) |=> state == CQ_HIT);
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state == CQ_HIT && coll_cond && link_ok) |=> state == CQ_HIT);
    p_link_clear_r12: assert property (@(posedge clk) disable iff (rst)
        !link_ok |=> (state == CQ_IDLE && cnt == '0));
endmodule

// File: rtl/sqe_gen.sv
module sqe_gen
    import sense_pkg::*;
#(
    parameter int DELAY_BITS = 10,
    parameter int PULSE_BITS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic link_ok,
    input  logic bit_stb,
    input  logic spd_100,
    input  logic hb_en,
    input  logic tx_act,
    output logic sqe
);
    localparam int MAXB = (DELAY_BITS > PULSE_BITS) ? DELAY_BITS : PULSE_BITS;
    localparam int CW   = $clog2(MAXB + 1);

    hb_state_t state, nxt;
    logic [CW-1:0] cnt, cnt_n;
    logic tx_prev;
    logic tx_end;

    assign tx_end = tx_prev && !tx_act && hb_en && !spd_100;

    always_ff @(posedge clk) begin
        if (rst || !link_ok) begin
            state   <= HB_IDLE;
            cnt     <= '0;
            tx_prev <= 1'b0;
        end else begin
            state   <= nxt;
            cnt     <= cnt_n;
            tx_prev <= tx_act;
        end
    end

    always_comb begin
        nxt   = state;
        cnt_n = cnt;
        unique case (state)
            HB_IDLE: begin
                if (tx_end) begin
                    nxt   = HB_DELAY;
                    cnt_n = '0;
                end
            end
            HB_DELAY: begin
                if (tx_act) begin
                    nxt   = HB_IDLE;
                    cnt_n = '0;
                end else if (bit_stb) begin
                    if (cnt == CW'(DELAY_BITS - 1)) begin
                        nxt   = HB_PULSE;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
            end
            HB_PULSE: begin
                if (bit_stb) begin
                    if (cnt == CW'(PULSE_BITS - 1)) begin
                        nxt   = HB_IDLE;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
            end
            default: nxt = HB_IDLE;
        endcase
    end

    always_comb begin
        sqe = (state == HB_PULSE);
    end

    p_no_fast_hb_r5: assert property (@(posedge clk) disable iff (rst)
        (state == HB_IDLE && spd_100) |=> state == HB_IDLE);
    p_cancel_r6: assert property (@(posedge clk) disable iff (rst)
        (state == HB_DELAY && tx_act) |=> state == HB_IDLE);
    p_link_clear_r12: assert property (@(posedge clk) disable iff (rst)
        !link_ok |=> state == HB_IDLE);
endmodule

// File: rtl/ssd_lock.sv
module ssd_lock
    import sense_pkg::*;
#(
    parameter int WIN = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic link_ok,
    input  logic spd_100,
    input  logic bit_stb,
    input  logic rx_bit,
    input  logic eop,
    output logic locked
);
    localparam int CW = $clog2(WIN + 1);

    sd_state_t state, nxt;
    logic [CW-1:0] cnt, cnt_n;

    always_ff @(posedge clk) begin
        if (rst || !link_ok || !spd_100) begin
            state <= SD_HUNT;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        nxt   = state;
        cnt_n = cnt;
        if (eop) begin
            nxt   = SD_HUNT;
            cnt_n = '0;
        end else begin
            unique case (state)
                SD_HUNT: begin
                    if (bit_stb && !rx_bit) begin
                        nxt   = SD_ARMED;
                        cnt_n = '0;
                    end
                end
                SD_ARMED: begin
                    if (bit_stb) begin
                        if (!rx_bit) begin
                            if (cnt == '0) cnt_n = '0;   // adjacent zero re-arms
                            else           nxt   = SD_LOCK;
                        end else if (cnt == CW'(WIN - 1)) begin
                            nxt   = SD_HUNT;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt + CW'(1);
                        end
                    end
                end
                SD_LOCK: nxt = SD_LOCK;
                default: nxt = SD_HUNT;
            endcase
        end
    end

    always_comb begin
        locked = (state == SD_LOCK);
    end

    p_rearm_r9: assert property (@(posedge clk) disable iff (rst)
        (state == SD_ARMED && bit_stb && !rx_bit && cnt == '0 && !eop && link_ok && spd_100)
        |=> (state == SD_ARMED && cnt == '0));
    p_eop_drop_r11: assert property (@(posedge clk) disable iff (rst)
        eop |=> state != SD_LOCK);
    p_window_r10: assert property (@(posedge clk) disable iff (rst)
        (state == SD_ARMED) |-> (cnt < CW'(WIN)));
    p_link_clear_r12: assert property (@(posedge clk) disable iff (rst)
        !link_ok |=> state == SD_HUNT);
endmodule

// File: rtl/mii_sense_ctrl.sv
module mii_sense_ctrl #(
    parameter int QUAL_BITS  = 7,
    parameter int DELAY_BITS = 10,
    parameter int PULSE_BITS = 10,
    parameter int SSD_WIN    = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_stb,
    input  logic spd_100,
    input  logic full_dup,
    input  logic hb_en,
    input  logic tx_act,
    input  logic rx_vld,
    input  logic eop,
    input  logic link_ok,
    input  logic rx_bit,
    output logic crs,
    output logic col
);
    logic col_hit;
    logic sqe;
    logic ssd_ok;
    logic rx_carrier;

    col_qual #(.QUAL_BITS(QUAL_BITS)) u_col (
        .clk(clk), .rst(rst), .link_ok(link_ok), .bit_stb(bit_stb),
        .spd_100(spd_100), .full_dup(full_dup), .tx_act(tx_act),
        .rx_vld(rx_vld), .col_hit(col_hit)
    );

    sqe_gen #(.DELAY_BITS(DELAY_BITS), .PULSE_BITS(PULSE_BITS)) u_sqe (
        .clk(clk), .rst(rst), .link_ok(link_ok), .bit_stb(bit_stb),
        .spd_100(spd_100), .hb_en(hb_en), .tx_act(tx_act), .sqe(sqe)
    );

    ssd_lock #(.WIN(SSD_WIN)) u_ssd (
        .clk(clk), .rst(rst), .link_ok(link_ok), .spd_100(spd_100),
        .bit_stb(bit_stb), .rx_bit(rx_bit), .eop(eop), .locked(ssd_ok)
    );

    always_comb begin
        rx_carrier = spd_100 ? ssd_ok : rx_vld;
        crs = link_ok && !rst && (rx_carrier || (!full_dup && tx_act));
        col = link_ok && !rst && (col_hit || sqe);
    end

    p_fdx_tx_only_r7: assert property (@(posedge clk) disable iff (rst)
        (full_dup && !rx_vld && !spd_100) |-> !crs);
endmodule

// File: tb/sim_mii_sense_ctrl.sv
module sim_mii_sense_ctrl;
    logic clk = 1'b0;
    logic rst, bit_stb, spd_100, full_dup, hb_en, tx_act, rx_vld, eop, link_ok, rx_bit;
    logic crs, col;
    int   nvec = 0;
    int   nerr = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    mii_sense_ctrl u0 (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .spd_100(spd_100),
        .full_dup(full_dup), .hb_en(hb_en), .tx_act(tx_act), .rx_vld(rx_vld),
        .eop(eop), .link_ok(link_ok), .rx_bit(rx_bit), .crs(crs), .col(col)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic bstrobe(input logic b);
        rx_bit  = b;
        bit_stb = 1'b1;
        tick();
        bit_stb = 1'b0;
        rx_bit  = 1'b1;
        tick();
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic quiet();
        tx_act = 1'b0;
        rx_vld = 1'b0;
        tick();
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bit_stb = 1'b0; spd_100 = 1'b0; full_dup = 1'b0; hb_en = 1'b0;
        tx_act = 1'b0; rx_vld = 1'b0; eop = 1'b0; link_ok = 1'b1; rx_bit = 1'b1;
        tick(); tick(); tick();
        chk(crs, 1'b0, "R12 crs in reset");
        chk(col, 1'b0, "R12 col in reset");
        rst = 1'b0;
        tick();
        chk(crs, 1'b0, "R12 crs after reset");
        chk(col, 1'b0, "R12 col after reset");

        // R2 transmit-first at 10 Mb/s: strobe count sweep
        tx_act = 1'b1; tick();
        chk(col, 1'b0, "R1 tx only no col");
        chk(crs, 1'b1, "R7 half duplex tx crs");
        rx_vld = 1'b1; tick();
        chk(col, 1'b0, "R2 onset filtered");
        for (int i = 1; i <= 7; i++) begin
            bstrobe(1'b1);
            chk(col, (i >= 7), "R2 seven-bit qualify");
        end
        // R4 held then released
        repeat (5) begin tick(); chk(col, 1'b1, "R4 col held"); end
        rx_vld = 1'b0; tick();
        chk(col, 1'b0, "R4 col release");
        quiet();

        // R3 receive-first at 10 Mb/s
        rx_vld = 1'b1; tick();
        chk(crs, 1'b1, "R7 rx crs 10M");
        tx_act = 1'b1; tick();
        chk(col, 1'b1, "R3 rx-first immediate");
        tx_act = 1'b0; tick();
        chk(col, 1'b0, "R4 release on tx end");
        quiet();

        // R3 at 100 Mb/s, transmit first
        spd_100 = 1'b1; tick();
        tx_act = 1'b1; tick();
        rx_vld = 1'b1; tick();
        chk(col, 1'b1, "R3 100M immediate");
        quiet();
        spd_100 = 1'b0; tick();

        // R1 full duplex, both active
        full_dup = 1'b1; tick();
        tx_act = 1'b1; rx_vld = 1'b1; tick();
        for (int i = 0; i < 10; i++) begin
            bstrobe(1'b1);
            chk(col, 1'b0, "R1 full duplex no col");
        end
        rx_vld = 1'b0; tick();
        chk(crs, 1'b0, "R7 full duplex tx ignored");
        tx_act = 1'b0; tick();
        rx_vld = 1'b1; tick();
        chk(crs, 1'b1, "R7 full duplex rx crs");
        rx_vld = 1'b0; tick();
        chk(crs, 1'b0, "R11 crs falls with rx_vld");
        full_dup = 1'b0; tick();

        // R5 heartbeat sweep
        hb_en = 1'b1; tick();
        tx_act = 1'b1; tick();
        tx_act = 1'b0; tick();
        for (int i = 1; i <= 10; i++) begin
            bstrobe(1'b1);
            chk(col, (i == 10), "R5 heartbeat delay");
        end
        for (int i = 1; i <= 10; i++) begin
            bstrobe(1'b1);
            chk(col, (i < 10), "R5 heartbeat width");
        end
        // R5 disabled
        hb_en = 1'b0; tick();
        tx_act = 1'b1; tick(); tx_act = 1'b0; tick();
        for (int i = 0; i < 25; i++) begin
            bstrobe(1'b1);
            chk(col, 1'b0, "R5 heartbeat off");
        end
        // R5 no heartbeat at 100 Mb/s
        hb_en = 1'b1; spd_100 = 1'b1; tick();
        tx_act = 1'b1; tick(); tx_act = 1'b0; tick();
        for (int i = 0; i < 25; i++) begin
            bstrobe(1'b1);
            chk(col, 1'b0, "R5 no heartbeat 100M");
        end
        spd_100 = 1'b0; tick();

        // R6 cancel on new transmission
        tx_act = 1'b1; tick(); tx_act = 1'b0; tick();
        for (int i = 0; i < 5; i++) bstrobe(1'b1);
        tx_act = 1'b1; tick();
        for (int i = 0; i < 20; i++) begin
            bstrobe(1'b1);
            chk(col, 1'b0, "R6 pulse cancelled");
        end
        tx_act = 1'b0; tick();
        for (int i = 1; i <= 10; i++) begin
            bstrobe(1'b1);
            chk(col, (i == 10), "R6 fresh delay");
        end
        for (int i = 0; i < 10; i++) bstrobe(1'b1);
        chk(col, 1'b0, "R6 pulse ended");
        hb_en = 1'b0; tick();

        // R8 / R10 start-of-stream gap sweep at 100 Mb/s
        spd_100 = 1'b1; full_dup = 1'b1; tick();
        for (int g = 1; g <= 12; g++) begin
            bstrobe(1'b1); bstrobe(1'b1);
            bstrobe(1'b0);
            for (int k = 0; k < g - 1; k++) bstrobe(1'b1);
            bstrobe(1'b0);
            chk(crs, (g >= 2 && g <= 10), (g > 10) ? "R10 window expiry" : "R8 two-zero lock");
            for (int k = 0; k < 12; k++) bstrobe(1'b1);
            chk(crs, (g >= 2 && g <= 10), "R8 lock persistence");
            eop = 1'b1; tick(); eop = 1'b0;
            chk(crs, 1'b0, "R11 crs drops after eop");
            tick();
        end

        // R9 adjacent zeros re-arm
        bstrobe(1'b0); bstrobe(1'b0);
        chk(crs, 1'b0, "R9 adjacent no lock");
        bstrobe(1'b1); bstrobe(1'b0);
        chk(crs, 1'b1, "R9 second zero is new first");
        eop = 1'b1; tick(); eop = 1'b0; tick();

        // R12 link loss clears detector
        bstrobe(1'b0); bstrobe(1'b1); bstrobe(1'b0);
        chk(crs, 1'b1, "R8 lock before link loss");
        link_ok = 1'b0; tick();
        chk(crs, 1'b0, "R12 link down crs");
        link_ok = 1'b1; tick();
        chk(crs, 1'b0, "R12 lock cleared");
        spd_100 = 1'b0; full_dup = 1'b0; tick();

        // R12 link loss clears collision
        rx_vld = 1'b1; tick(); tx_act = 1'b1; tick();
        chk(col, 1'b1, "R3 collision before link loss");
        link_ok = 1'b0; tick();
        chk(col, 1'b0, "R12 link down col");
        chk(crs, 1'b0, "R12 link down crs rx");
        link_ok = 1'b1; tick();
        tick();
        chk(col, 1'b0, "R12 collision requalified");
        quiet();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule